// File: doc/BRIEF.md
# Capability-aware leaf PTE checker

This block judges one leaf page-table entry of a 39/48-bit style virtual memory scheme whose top five bits carry capability permissions. For each request it takes the 64-bit entry, the kind of access, the current privilege, the supervisor-user-memory flag and two global load-generation bits. One cycle later it reports at most one fault, either an ordinary page fault or a capability fault. On success it also reports the entry with its accessed, dirty and capability-dirty bits updated, a write-back request, and three page attributes for the TLB fill.

The attributes are capability-load tag clearing, capability-load trapping and capability-store trapping. They tell later pipeline stages what to do with tagged loads and stores to the page. The walker, the memory port and the TLB array sit around this block and are not part of it.

Entry bit positions used throughout: V=0, R=1, W=2, X=3, U=4, A=6, D=7, gen=59, gen-mode=60, cap-dirty=61, cap-read=62, cap-write=63. Access kind encoding: 0 fetch, 1 load, 2 store, 3 capability store. Privilege 0 is user; any other value is supervisor.

Top module: `cap_pte_check`

## Requirements
- R1: An entry with W=1, X=1 and R=0 gives a page fault.
- R2: An entry with gen=1 and cap-read=0 gives a capability fault.
- R3: An entry with cap-read=1, gen=1 and gen-mode=0 gives a capability fault.
- R4: An entry with U=1 gives a page fault in supervisor mode when SUM is 0 or the access is a fetch. An entry with U=0 gives a page fault in user mode.
- R5: A fetch needs X, a load needs R, and a store or capability store needs W. Otherwise a page fault is given.
- R6: A capability store to an entry with cap-write=0 gives a capability fault. On any successful access, the store-trap attribute equals the inverse of cap-write.
- R7: On success the updated entry has A set. A store also sets D, and a capability store sets D and cap-dirty. The write-back request is 1 exactly when the updated entry differs from the input.
- R8: On success with cap-read=0, gen-mode=0 sets the tag-clear attribute and gen-mode=1 sets the load-trap attribute.
- R9: On success with cap-read=1 and gen-mode=1, the global bit is selected by U: the user global bit if U=1, else the supervisor global bit. If that bit differs from gen, the load-trap attribute is set.
- R10: With parameters TRAP_A, TRAP_D and TRAP_CD set, the block reports a fault instead of setting the bit. A clear A gives a page fault. A clear D on a store or capability store gives a page fault. A clear cap-dirty on a capability store gives a capability fault.
- R11: Checks are applied in the order R1, R2, R3, R4, R5, R6 (cap-write), R10. Only the first failing check is reported, and never both fault kinds at once. A faulting response carries the input entry unchanged, no write-back and all attributes 0.
- R12: Every output is registered and appears in the cycle after the request strobe. Without a strobe, rsp_valid, both faults, the write-back, the attributes and the entry output are all 0, as they are in reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| pte_in | input | 64 | Leaf entry under test |
| acc_kind | input | 2 | 0 fetch, 1 load, 2 store, 3 capability store |
| priv | input | 2 | 0 user, other supervisor |
| sum | input | 1 | Supervisor may access user pages |
| glob_gen_u | input | 1 | Global load generation for user pages |
| glob_gen_s | input | 1 | Global load generation for supervisor pages |
| rsp_valid | output | 1 | Response present |
| page_fault | output | 1 | Ordinary page fault |
| cap_fault | output | 1 | Capability fault |
| pte_out | output | 64 | Updated entry (input entry on fault) |
| wb_req | output | 1 | Updated entry must be written back |
| ld_tag_clear | output | 1 | Capability loads clear the tag |
| ld_trap | output | 1 | Capability loads trap |
| st_trap | output | 1 | Capability stores trap |

## Verification
Several checks can fail on one entry in the same cycle. This happens when an entry carries both reserved encodings, when a capability store lacks both W and cap-write, or when a capability store with cap-write clear also lacks cap-dirty while trapping is enabled. The bench sends such entries and judges that only the higher-priority fault kind is raised. A second case is an access that both succeeds with a write-back and raises load or store attributes in the same response. The bench judges the updated entry and the attributes together in one comparison. A second instance with all trap parameters set receives the same stimulus, so the default and trapping variants can be compared on identical entries.

// File: rtl/cap_pte_check.sv
module cap_pte_check #(
  parameter bit TRAP_A  = 1'b0,
  parameter bit TRAP_D  = 1'b0,
  parameter bit TRAP_CD = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [63:0] pte_in,
  input  logic [1:0]  acc_kind,
  input  logic [1:0]  priv,
  input  logic        sum,
  input  logic        glob_gen_u,
  input  logic        glob_gen_s,
  output logic        rsp_valid,
  output logic        page_fault,
  output logic        cap_fault,
  output logic [63:0] pte_out,
  output logic        wb_req,
  output logic        ld_tag_clear,
  output logic        ld_trap,
  output logic        st_trap
);
  localparam int BR = 1, BW = 2, BX = 3, BU = 4, BA = 6, BD = 7;
  localparam int BGEN = 59, BGMOD = 60, BCD = 61, BCR = 62, BCW = 63;

  wire r = pte_in[BR], w = pte_in[BW], x = pte_in[BX], u = pte_in[BU];
  wire a = pte_in[BA], d = pte_in[BD];
  wire gen = pte_in[BGEN], gmod = pte_in[BGMOD], cd = pte_in[BCD];
  wire cr = pte_in[BCR], cw = pte_in[BCW];

  wire is_fetch = (acc_kind == 2'd0);
  wire is_load  = (acc_kind == 2'd1);
  wire is_cst   = (acc_kind == 2'd3);
  wire is_wr    = acc_kind[1];
  wire user     = (priv == 2'd0);

  wire f_rwx  = w & x & ~r;
  wire f_gen  = gen & ~cr;
  wire f_gmod = cr & gen & ~gmod;
  wire f_priv = user ? ~u : (u & (~sum | is_fetch));
  wire f_perm = is_fetch ? ~x : (is_load ? ~r : ~w);
  wire f_cw   = is_cst & ~cw;
  wire f_ta   = TRAP_A & ~a;
  wire f_td   = TRAP_D & is_wr & ~d;
  wire f_tcd  = TRAP_CD & is_cst & ~cd;

  logic pf_n, cf_n;
  always_comb begin
    pf_n = 1'b0;
    cf_n = 1'b0;
    if (f_rwx)       pf_n = 1'b1;
    else if (f_gen)  cf_n = 1'b1;
    else if (f_gmod) cf_n = 1'b1;
    else if (f_priv) pf_n = 1'b1;
    else if (f_perm) pf_n = 1'b1;
    else if (f_cw)   cf_n = 1'b1;
    else if (f_ta)   pf_n = 1'b1;
    else if (f_td)   pf_n = 1'b1;
    else if (f_tcd)  cf_n = 1'b1;
  end

  wire ok = ~(pf_n | cf_n);

  logic [63:0] upd;
  always_comb begin
    upd = pte_in;
    upd[BA] = 1'b1;
    if (is_wr)  upd[BD]  = 1'b1;
    if (is_cst) upd[BCD] = 1'b1;
  end

  wire gsel     = u ? glob_gen_u : glob_gen_s;
  wire clr_n    = ok & ~cr & ~gmod;
  wire ltrap_n  = ok & ((~cr & gmod) | (cr & gmod & (gsel != gen)));
  wire strap_n  = ok & ~cw;
  wire wb_n     = ok & (upd != pte_in);

  always_ff @(posedge clk) begin
    if (!rst_n || !req_valid) begin
      rsp_valid    <= 1'b0;
      page_fault   <= 1'b0;
      cap_fault    <= 1'b0;
      pte_out      <= '0;
      wb_req       <= 1'b0;
      ld_tag_clear <= 1'b0;
      ld_trap      <= 1'b0;
      st_trap      <= 1'b0;
    end else begin
      rsp_valid    <= 1'b1;
      page_fault   <= pf_n;
      cap_fault    <= cf_n;
      pte_out      <= ok ? upd : pte_in;
      wb_req       <= wb_n;
      ld_tag_clear <= clr_n;
      ld_trap      <= ltrap_n;
      st_trap      <= strap_n;
    end
  end

  p_one_fault_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(page_fault && cap_fault));

  p_rsp_follows_r12: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !page_fault && !cap_fault && !wb_req));

  p_rwx_pf_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && pte_in[BW] && pte_in[BX] && !pte_in[BR]) |=> page_fault);

  p_gen_cf_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && pte_in[BGEN] && !pte_in[BCR] && !(pte_in[BW] && pte_in[BX] && !pte_in[BR]))
      |=> cap_fault);

  p_store_needs_w_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && acc_kind == 2'd2 && !pte_in[BW]) |=> (page_fault || cap_fault));

  p_cst_marks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && acc_kind == 2'd3) |=>
      (page_fault || cap_fault || (pte_out[BA] && pte_out[BD] && pte_out[BCD])));

  p_wb_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req |-> (pte_out[BA] && !page_fault && !cap_fault));

  p_ld_attr_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_tag_clear && ld_trap));

  p_fault_no_attr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (page_fault || cap_fault) |-> !(ld_tag_clear || ld_trap || st_trap || wb_req));
endmodule

// File: tb/sim_cap_pte_check.sv
module sim_cap_pte_check;
  localparam int CLK_PERIOD = 10;

  localparam logic [63:0] PR = 64'h2, PW = 64'h4, PX = 64'h8, PU = 64'h10;
  localparam logic [63:0] PA = 64'h40, PD = 64'h80;
  localparam logic [63:0] PGEN = 64'h0800_0000_0000_0000;
  localparam logic [63:0] PGMOD = 64'h1000_0000_0000_0000;
  localparam logic [63:0] PCD = 64'h2000_0000_0000_0000;
  localparam logic [63:0] PCR = 64'h4000_0000_0000_0000;
  localparam logic [63:0] PCW = 64'h8000_0000_0000_0000;

  // {req, pte, kind, priv(S=1), sum, gu, gs, pf, cf, clr, ltrap, strap}
  localparam int NV = 21;
  localparam logic [78:0] VEC [NV] = '{
    {4'd1,  PW|PX,                 2'd1, 4'b1000, 5'b10000}, // R1
    {4'd2,  PR|PGEN,               2'd1, 4'b1000, 5'b01000}, // R2
    {4'd3,  PR|PCR|PGEN,           2'd1, 4'b1000, 5'b01000}, // R3
    {4'd11, PW|PX|PGEN,            2'd1, 4'b1000, 5'b10000}, // R11
    {4'd4,  PR|PU,                 2'd1, 4'b1000, 5'b10000}, // R4
    {4'd4,  PR|PU|PX,              2'd0, 4'b1100, 5'b10000}, // R4
    {4'd4,  PR|PU,                 2'd1, 4'b1100, 5'b00101}, // R4
    {4'd4,  PR,                    2'd1, 4'b0000, 5'b10000}, // R4
    {4'd5,  PX,                    2'd1, 4'b1000, 5'b10000}, // R5
    {4'd5,  PR,                    2'd2, 4'b1000, 5'b10000}, // R5
    {4'd6,  PR|PW,                 2'd3, 4'b1000, 5'b01000}, // R6
    {4'd7,  PR|PW|PCW|PCR,         2'd3, 4'b1000, 5'b00000}, // R7
    {4'd7,  PR|PW|PA|PD,           2'd2, 4'b1000, 5'b00101}, // R7
    {4'd9,  PR|PCR|PGMOD|PU,       2'd1, 4'b0010, 5'b00011}, // R9
    {4'd9,  PR|PCR|PGMOD|PGEN|PU,  2'd1, 4'b0010, 5'b00001}, // R9
    {4'd9,  PR|PCR|PGMOD|PGEN,     2'd1, 4'b1010, 5'b00011}, // R9
    {4'd8,  PR|PGMOD,              2'd1, 4'b1000, 5'b00011}, // R8
    {4'd11, PR,                    2'd3, 4'b1000, 5'b10000}, // R11
    {4'd7,  PX|PCR|PCW,            2'd0, 4'b1000, 5'b00000}, // R7
    {4'd8,  PX|PU,                 2'd0, 4'b0000, 5'b00101}, // R8
    {4'd7,  PR|PW|PU,              2'd2, 4'b1100, 5'b00101}  // R7
  };

  logic clk = 1'b0, rst_n = 1'b0, req_valid = 1'b0;
  logic [63:0] pte_in = '0;
  logic [1:0] acc_kind = '0, priv = '0;
  logic sum = 1'b0, glob_gen_u = 1'b0, glob_gen_s = 1'b0;

  logic rv0, pf0, cf0, wb0, clr0, lt0, st0;
  logic rv1, pf1, cf1, wb1, clr1, lt1, st1;
  logic [63:0] po0, po1;

  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cap_pte_check u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .pte_in(pte_in),
    .acc_kind(acc_kind), .priv(priv), .sum(sum), .glob_gen_u(glob_gen_u),
    .glob_gen_s(glob_gen_s), .rsp_valid(rv0), .page_fault(pf0), .cap_fault(cf0),
    .pte_out(po0), .wb_req(wb0), .ld_tag_clear(clr0), .ld_trap(lt0), .st_trap(st0));

  cap_pte_check #(.TRAP_A(1'b1), .TRAP_D(1'b1), .TRAP_CD(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .pte_in(pte_in),
    .acc_kind(acc_kind), .priv(priv), .sum(sum), .glob_gen_u(glob_gen_u),
    .glob_gen_s(glob_gen_s), .rsp_valid(rv1), .page_fault(pf1), .cap_fault(cf1),
    .pte_out(po1), .wb_req(wb1), .ld_tag_clear(clr1), .ld_trap(lt1), .st_trap(st1));

  function automatic logic [63:0] exp_pte(input logic [63:0] p, input logic [1:0] k,
                                          input logic flt);
    logic [63:0] e;
    e = p;
    if (!flt) begin
      e = e | PA;
      if (k[1]) e = e | PD;
      if (k == 2'd3) e = e | PCD;
    end
    return e;
  endfunction

  task automatic cmp(input string tag, input logic [70:0] act, input logic [70:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [63:0] p, input logic [1:0] k, input logic [1:0] pv,
                       input logic s, input logic gu, input logic gs);
    @(negedge clk);
    req_valid = 1'b1; pte_in = p; acc_kind = k; priv = pv;
    sum = s; glob_gen_u = gu; glob_gen_s = gs;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  function automatic logic [70:0] pack(input logic [63:0] p, input logic [1:0] k,
                                       input logic pf, input logic cf, input logic clr,
                                       input logic lt, input logic st);
    logic [63:0] e;
    logic flt;
    flt = pf | cf;
    e = exp_pte(p, k, flt);
    return {1'b1, pf, cf, (!flt && e != p), clr, lt, st, e};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    cmp("R12 reset", {rv0, pf0, cf0, wb0, clr0, lt0, st0, po0}, '0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [78:0] v;
      v = VEC[i];
      drive(v[74:11], v[10:9], {1'b0, v[8]}, v[7], v[6], v[5]);
      cmp($sformatf("R%0d vector %0d", v[78:75], i),
          {rv0, pf0, cf0, wb0, clr0, lt0, st0, po0},
          pack(v[74:11], v[10:9], v[4], v[3], v[2], v[1], v[0]));
    end

    // R12: no strobe after a faulting request
    drive(PW|PX, 2'd1, 2'd1, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    cmp("R12 idle", {rv0, pf0, cf0, wb0, clr0, lt0, st0, po0}, '0);

    // R10: clear A traps only when enabled
    drive(PR, 2'd1, 2'd1, 1'b0, 1'b0, 1'b0);
    cmp("R10 A trap", {rv1, pf1, cf1, wb1, clr1, lt1, st1, po1},
        pack(PR, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0));
    cmp("R10 A default", {rv0, pf0, cf0, wb0, clr0, lt0, st0, po0},
        pack(PR, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1));

    // R10: clear D on store
    drive(PR|PW|PA, 2'd2, 2'd1, 1'b0, 1'b0, 1'b0);
    cmp("R10 D trap", {rv1, pf1, cf1, wb1, clr1, lt1, st1, po1},
        pack(PR|PW|PA, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0));

    // R10: clear cap-dirty on capability store
    drive(PR|PW|PA|PD|PCW, 2'd3, 2'd1, 1'b0, 1'b0, 1'b0);
    cmp("R10 CD trap", {rv1, pf1, cf1, wb1, clr1, lt1, st1, po1},
        pack(PR|PW|PA|PD|PCW, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0));
    cmp("R7 CD set default", {rv0, pf0, cf0, wb0, clr0, lt0, st0, po0},
        pack(PR|PW|PA|PD|PCW, 2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0));

    // R11: cap-write fault outranks cap-dirty trap
    drive(PR|PW|PA|PD, 2'd3, 2'd1, 1'b0, 1'b0, 1'b0);
    cmp("R11 CW before CD trap", {rv1, pf1, cf1, wb1, clr1, lt1, st1, po1},
        pack(PR|PW|PA|PD, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0));

    // R10: all bits present, trapping instance succeeds without write-back
    drive(PR|PW|PA|PD|PCW|PCD, 2'd3, 2'd1, 1'b0, 1'b0, 1'b0);
    cmp("R10 all set", {rv1, pf1, cf1, wb1, clr1, lt1, st1, po1},
        pack(PR|PW|PA|PD|PCW|PCD, 2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule